// File: doc/BRIEF.md
# Multi-Bank Video Raster Mode Selector

This block keeps several sets of raster timing values, which a host writes through a simple word-addressed slave port. It selects one set automatically and drives the active-video, horizontal sync and vertical sync outputs of a video output stage from it. Each set is one mode. A mode holds its active size, its porches and its sync widths, together with a flag that marks it as usable. The timing words are write-only. Only the first few control words read back.

A frame-size control packet on the stream input starts a search. The block picks the lowest-numbered usable mode whose active width and height equal the sizes in the packet. That mode is held as pending and is copied into the raster generator at the next frame boundary, or at once if the raster is stopped. A run bit starts and stops the raster. When the host clears it, the current frame still completes, and only then does the running status bit drop. The host polls that bit before it reprograms a mode.

Top module: `vidModeSel`

## Requirements
- R1: After reset, activeVideo, hSync and vSync are low, and words 0, 1 and 2 read 0.
- R2: Word 0 bit 0 is the run bit and reads back. Word 1 reads {noMatch at bit 1, running at bit 0}. Word 2 reads {loaded at bit 8, index of the active mode in the low bits}. Every mode word (base 16+16·m; offsets 0..7 = hAct, hFront, hSync, hBack, vAct, vFront, vSync, vBack; offset 8 bit 0 = usable flag) reads 0.
- R3: A packet {type[27:24], width[23:12], height[11:0]} starts a mode search only when the type is 0xF. Packets of any other type leave the selected mode unchanged.
- R4: When several usable modes match the packet size, the lowest-numbered one is selected.
- R5: A mode whose usable flag is 0 is skipped, even if its size matches. The next matching usable mode is then taken.
- R6: A search that finds no usable match sets noMatch and keeps the current mode. A later successful search clears noMatch.
- R7: Each line is hAct active pixels, then hFront, hSync and hBack blank pixels. Frames are built the same way from lines. hSync and vSync are active high during their sync intervals, and activeVideo is high only inside the active area.
- R8: A newly selected mode takes effect only when the running raster is at the last pixel of a frame.
- R9: After the run bit is cleared, the raster finishes the current frame and then clears running. All three outputs stay low while running is 0.
- R10: The raster starts at pixel 0 of line 0 once the run bit is set and a mode has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 8 | Host word address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data for hostAddr (combinational) |
| pktValid | input | 1 | Control packet strobe |
| pktData | input | 28 | Control packet {type, width, height} |
| activeVideo | output | 1 | High inside the active picture area |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |

## Verification
The bench programs two modes with the same size but different porches. Selection priority can then be told apart from the measured frame length and the sync widths. A selector that scans from the top would report mode 1 while both modes are usable. A selector that ignores the usable flag would stay on mode 0 after that mode is cleared. The bench also sends a packet of the wrong type and a packet whose size matches no mode. A design that decodes every packet type, or that drops its mode on a failed search, would change the reported index. For the stop sequence, the run bit is cleared just after a vsync rise. A design that stops at once would clear running immediately, and one that never stops would leave sync pulses on the outputs.

// File: rtl/vidModePkg.sv
package vidModePkg;
  localparam int CW = 12;
  localparam int TW = CW + 2;
  localparam int MODE_BASE_BLK = 1;
  localparam int OFF_VALID = 8;

  typedef struct packed {
    logic [CW-1:0] hAct;
    logic [CW-1:0] hFront;
    logic [CW-1:0] hSync;
    logic [CW-1:0] hBack;
    logic [CW-1:0] vAct;
    logic [CW-1:0] vFront;
    logic [CW-1:0] vSync;
    logic [CW-1:0] vBack;
  } timing_t;

  typedef struct packed {
    logic load;
    logic start;
  } strobe_t;
endpackage

// File: rtl/vidModeBank.sv
module vidModeBank
  import vidModePkg::*;
#(
  parameter int NUM_MODES = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output timing_t           bankTim [NUM_MODES],
  output logic [NUM_MODES-1:0] bankValid,
  output logic              goBit,
  input  logic              running,
  input  logic              noMatch,
  input  logic              loaded,
  input  logic [IDX_W-1:0]  activeIdx
);
  localparam int BLK_W = ADDR_W - 4;

  logic unusedWdata;
  assign unusedWdata = ^hostWdata[DATA_W-1:CW];

  always_ff @(posedge clk) begin
    if (!rstN) goBit <= 1'b0;
    else if (hostWe && hostAddr == '0) goBit <= hostWdata[0];
  end

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    logic hitBlk;
    assign hitBlk = hostWe && (hostAddr[ADDR_W-1:4] == BLK_W'(MODE_BASE_BLK + m));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankTim[m]   <= '0;
        bankValid[m] <= 1'b0;
      end else if (hitBlk) begin
        case (hostAddr[3:0])
          4'd0: bankTim[m].hAct   <= hostWdata[CW-1:0];
          4'd1: bankTim[m].hFront <= hostWdata[CW-1:0];
          4'd2: bankTim[m].hSync  <= hostWdata[CW-1:0];
          4'd3: bankTim[m].hBack  <= hostWdata[CW-1:0];
          4'd4: bankTim[m].vAct   <= hostWdata[CW-1:0];
          4'd5: bankTim[m].vFront <= hostWdata[CW-1:0];
          4'd6: bankTim[m].vSync  <= hostWdata[CW-1:0];
          4'd7: bankTim[m].vBack  <= hostWdata[CW-1:0];
          4'(OFF_VALID): bankValid[m] <= hostWdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    hostRdata = '0;
    case (hostAddr)
      ADDR_W'(0): hostRdata[0] = goBit;
      ADDR_W'(1): hostRdata[1:0] = {noMatch, running};
      ADDR_W'(2): begin
        hostRdata[8] = loaded;
        hostRdata[IDX_W-1:0] = activeIdx;
      end
      default: hostRdata = '0;
    endcase
  end
endmodule

// File: rtl/vidModeCtrl.sv
module vidModeCtrl
  import vidModePkg::*;
#(
  parameter int NUM_MODES = 2,
  parameter int IDX_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktValid,
  input  logic [4+2*CW-1:0] pktData,
  input  logic [CW-1:0]     bankW [NUM_MODES],
  input  logic [CW-1:0]     bankH [NUM_MODES],
  input  logic [NUM_MODES-1:0] bankValid,
  input  logic              goBit,
  input  logic              frameEnd,
  output strobe_t           ctlStrobe,
  output logic [IDX_W-1:0]  pendIdx,
  output logic [IDX_W-1:0]  activeIdx,
  output logic              running,
  output logic              loaded,
  output logic              noMatch
);
  logic [3:0]      pktType;
  logic [CW-1:0]   pktW, pktH;
  logic            hit, search, pendFlag, stopNow;
  logic [IDX_W-1:0] hitIdx;

  assign pktType = pktData[4+2*CW-1 -: 4];
  assign pktW    = pktData[2*CW-1 -: CW];
  assign pktH    = pktData[CW-1:0];
  assign search  = pktValid && (pktType == 4'hF);

  always_comb begin
    hit = 1'b0;
    hitIdx = '0;
    for (int m = NUM_MODES - 1; m >= 0; m--) begin
      if (bankValid[m] && bankW[m] == pktW && bankH[m] == pktH) begin
        hit = 1'b1;
        hitIdx = IDX_W'(m);
      end
    end
  end

  assign ctlStrobe.load  = pendFlag && (!running || frameEnd);
  assign ctlStrobe.start = !running && goBit && loaded;
  assign stopNow         = running && frameEnd && !goBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendFlag  <= 1'b0;
      pendIdx   <= '0;
      activeIdx <= '0;
      loaded    <= 1'b0;
      running   <= 1'b0;
      noMatch   <= 1'b0;
    end else begin
      if (ctlStrobe.load) begin
        pendFlag  <= 1'b0;
        activeIdx <= pendIdx;
        loaded    <= 1'b1;
      end
      if (search) begin
        if (hit) begin
          pendFlag <= 1'b1;
          pendIdx  <= hitIdx;
          noMatch  <= 1'b0;
        end else begin
          noMatch  <= 1'b1;
        end
      end
      if (ctlStrobe.start) running <= 1'b1;
      else if (stopNow)    running <= 1'b0;
    end
  end
endmodule

// File: rtl/vidModeRaster.sv
module vidModeRaster
  import vidModePkg::*;
#(
  parameter int NUM_MODES = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          ctlStrobe,
  input  logic             running,
  input  timing_t          bankTim [NUM_MODES],
  input  logic [IDX_W-1:0] pendIdx,
  output logic             frameEnd,
  output logic             activeVideo,
  output logic             hSync,
  output logic             vSync
);
  timing_t       cur;
  logic [TW-1:0] hCnt, vCnt;
  logic [TW-1:0] hSyncBeg, hSyncEnd, hTot, vSyncBeg, vSyncEnd, vTot;
  logic          lastH, lastV;

  assign hSyncBeg = TW'(cur.hAct) + TW'(cur.hFront);
  assign hSyncEnd = hSyncBeg + TW'(cur.hSync);
  assign hTot     = hSyncEnd + TW'(cur.hBack);
  assign vSyncBeg = TW'(cur.vAct) + TW'(cur.vFront);
  assign vSyncEnd = vSyncBeg + TW'(cur.vSync);
  assign vTot     = vSyncEnd + TW'(cur.vBack);

  assign lastH    = (hCnt == hTot - 1'b1);
  assign lastV    = (vCnt == vTot - 1'b1);
  assign frameEnd = running && lastH && lastV;

  always_ff @(posedge clk) begin
    if (!rstN) cur <= '0;
    else if (ctlStrobe.load) cur <= bankTim[pendIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN || !running || ctlStrobe.start) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lastH) begin
      hCnt <= '0;
      vCnt <= lastV ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  assign activeVideo = running && hCnt < TW'(cur.hAct) && vCnt < TW'(cur.vAct);
  assign hSync = running && hCnt >= hSyncBeg && hCnt < hSyncEnd;
  assign vSync = running && vCnt >= vSyncBeg && vCnt < vSyncEnd;
endmodule

// File: rtl/vidModeSel.sv
module vidModeSel
  import vidModePkg::*;
#(
  parameter int NUM_MODES = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              pktValid,
  input  logic [4+2*CW-1:0] pktData,
  output logic              activeVideo,
  output logic              hSync,
  output logic              vSync
);
  timing_t             bankTim [NUM_MODES];
  logic [CW-1:0]       bankW [NUM_MODES];
  logic [CW-1:0]       bankH [NUM_MODES];
  logic [NUM_MODES-1:0] bankValid;
  logic                goBit, running, loaded, noMatch, frameEnd;
  logic [IDX_W-1:0]    pendIdx, activeIdx;
  strobe_t             ctlStrobe;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_dim
    assign bankW[m] = bankTim[m].hAct;
    assign bankH[m] = bankTim[m].vAct;
  end

  vidModeBank #(.NUM_MODES(NUM_MODES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uBank (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .bankTim(bankTim), .bankValid(bankValid), .goBit(goBit),
    .running(running), .noMatch(noMatch), .loaded(loaded), .activeIdx(activeIdx));

  vidModeCtrl #(.NUM_MODES(NUM_MODES), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktData(pktData), .bankW(bankW),
    .bankH(bankH), .bankValid(bankValid), .goBit(goBit), .frameEnd(frameEnd),
    .ctlStrobe(ctlStrobe), .pendIdx(pendIdx), .activeIdx(activeIdx), .running(running),
    .loaded(loaded), .noMatch(noMatch));

  vidModeRaster #(.NUM_MODES(NUM_MODES), .IDX_W(IDX_W)) uRaster (
    .clk(clk), .rstN(rstN), .ctlStrobe(ctlStrobe), .running(running), .bankTim(bankTim),
    .pendIdx(pendIdx), .frameEnd(frameEnd), .activeVideo(activeVideo), .hSync(hSync),
    .vSync(vSync));
endmodule

// File: rtl/vidModeChecker.sv
module vidModeChecker (
  input logic clk,
  input logic rstN,
  input logic running,
  input logic loaded,
  input logic loadStb,
  input logic frameEnd,
  input logic activeVideo,
  input logic hSync,
  input logic vSync
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!activeVideo && !hSync && !vSync)); // R9
  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && running) |-> frameEnd); // R8
  AST_STOP_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (running && !frameEnd) |=> running); // R9
  AST_RUN_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    running |-> loaded); // R10
  AST_SYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    activeVideo |-> (!hSync && !vSync)); // R7
endmodule

bind vidModeSel vidModeChecker uChk (
  .clk(clk), .rstN(rstN), .running(running), .loaded(loaded), .loadStb(ctlStrobe.load),
  .frameEnd(frameEnd), .activeVideo(activeVideo), .hSync(hSync), .vSync(vSync));

// File: tb/tb_vidModeSel.sv
module tb_vidModeSel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        pktValid = 1'b0;
  logic [27:0] pktData = '0;
  logic        activeVideo, hSync, vSync;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { string tag; int act; int exp; } item_t;
  item_t scoreQ[$];

  always #5 clk = ~clk;

  vidModeSel dut (.clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .pktValid(pktValid), .pktData(pktData),
    .activeVideo(activeVideo), .hSync(hSync), .vSync(vSync));

  // monitor: pops queued items and compares
  always @(negedge clk) begin
    while (scoreQ.size() > 0) begin
      item_t it;
      it = scoreQ.pop_front();
      checks++;
      if (it.act != it.exp) begin
        errors++;
        $display("FAIL %s actual=%0d expected=%0d", it.tag, it.act, it.exp);
      end
    end
  end

  task automatic push(input string tag, input int act, input int exp);
    scoreQ.push_back('{tag, act, exp});
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 8'(addr); hostWdata = 32'(data);
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    hostAddr = 8'(addr);
    #1 data = int'(hostRdata);
  endtask

  task automatic sendPkt(input int typ, input int w, input int h);
    @(negedge clk);
    pktValid = 1'b1; pktData = {4'(typ), 12'(w), 12'(h)};
    @(negedge clk);
    pktValid = 1'b0;
  endtask

  task automatic progMode(input int m, input int ha, input int hf, input int hs, input int hb,
                          input int va, input int vf, input int vs, input int vb);
    int b = 16 + 16 * m;
    wr(b + 0, ha); wr(b + 1, hf); wr(b + 2, hs); wr(b + 3, hb);
    wr(b + 4, va); wr(b + 5, vf); wr(b + 6, vs); wr(b + 7, vb);
    wr(b + 8, 1);
  endtask

  task automatic waitVsRise();
    logic prev = vSync;
    forever begin
      @(negedge clk);
      if (vSync && !prev) break;
      prev = vSync;
    end
  endtask

  task automatic measure(output int len, output int act, output int hs);
    logic prev;
    waitVsRise();
    len = 1; act = activeVideo ? 1 : 0; hs = hSync ? 1 : 0; prev = vSync;
    forever begin
      @(negedge clk);
      if (vSync && !prev) break;
      prev = vSync;
      len++;
      if (activeVideo) act++;
      if (hSync) hs++;
    end
  endtask

  task automatic pollWord(input int addr, input int exp, input int limit, output int got);
    for (int i = 0; i < limit; i++) begin
      rd(addr, got);
      if (got == exp) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, len, act, hs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    push("R1 activeVideo", int'(activeVideo), 0);
    push("R1 hSync", int'(hSync), 0);
    push("R1 vSync", int'(vSync), 0);
    rd(0, v); push("R1 word0", v, 0);
    rd(1, v); push("R1 word1", v, 0);
    rd(2, v); push("R1 word2", v, 0);

    progMode(0, 4, 1, 2, 1, 3, 1, 1, 1);   // 8x6 total = 48
    progMode(1, 4, 2, 1, 3, 3, 2, 1, 1);   // 10x7 total = 70
    rd(16, v); push("R2 timing word reads 0", v, 0);
    rd(24, v); push("R2 valid word reads 0", v, 0);

    sendPkt(4'hF, 4, 3);
    repeat (3) @(negedge clk);
    rd(2, v); push("R4 lowest match selected", v, 32'h100);
    rd(1, v); push("R10 idle before run", v, 0);

    wr(0, 1);
    rd(0, v); push("R2 run bit readback", v, 1);
    repeat (2) @(negedge clk);
    rd(1, v); push("R10 running", v, 1);
    measure(len, act, hs);
    push("R7 mode0 frame length", len, 48);
    push("R7 mode0 active pixels", act, 12);
    push("R7 mode0 hsync cycles", hs, 12);

    wr(24, 0);                        // mode0 unusable
    sendPkt(4'hA, 4, 3);
    repeat (150) @(negedge clk);
    rd(2, v); push("R3 non-F packet ignored", v, 32'h100);

    waitVsRise();
    sendPkt(4'hF, 4, 3);
    repeat (2) @(negedge clk);
    rd(2, v); push("R8 no switch mid-frame", v, 32'h100);
    pollWord(2, 32'h101, 100, v);
    push("R5 invalid bank skipped", v, 32'h101);
    measure(len, act, hs);
    push("R7 mode1 frame length", len, 70);
    push("R7 mode1 active pixels", act, 12);
    push("R7 mode1 hsync cycles", hs, 7);

    sendPkt(4'hF, 9, 9);
    repeat (2) @(negedge clk);
    rd(1, v); push("R6 noMatch set", v, 3);
    repeat (150) @(negedge clk);
    rd(2, v); push("R6 mode kept", v, 32'h101);
    measure(len, act, hs);
    push("R6 frame unchanged", len, 70);

    wr(24, 1);                        // mode0 usable again
    sendPkt(4'hF, 4, 3);
    pollWord(2, 32'h100, 100, v);
    push("R4 lower bank wins again", v, 32'h100);
    rd(1, v); push("R6 noMatch cleared", v, 1);

    waitVsRise();
    wr(0, 0);
    rd(1, v); push("R9 still running mid-frame", v, 1);
    pollWord(1, 0, 60, v);
    push("R9 running cleared after frame", v, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (activeVideo || hSync || vSync) bad++;
      end
      push("R9 outputs quiet when stopped", bad, 0);
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule